// File: doc/BRIEF.md
# On-screen-display command decoder

This block sits behind a byte-level two-wire serial slave. The front end hands it each received byte together with pulses marking the start and stop conditions. The decoder turns the byte stream into register writes for an on-screen-display register space. That space has fifteen character rows of thirty columns, in two spaces: character codes, and attributes/control. One extra row of control registers sits at row 15 of the attribute/control space.

After the slave address, each byte is classified by its upper bits. It can be a row address, a random-access column address, or a streaming column address. With a random-access column, exactly one data byte follows. With a streaming column, every later byte is display data, and the address advances by itself after each write until the stop condition. A read transaction returns a single byte that carries a reset flag. Writing the screen-control register also produces one-cycle pulses that ask the neighbouring memories to clear the window enables or the display contents.

Top module: `osd_cmd_decoder`

## Requirements
- R1: The address byte after a start condition is acknowledged (`ack_o` high one cycle after the byte) when it is 0x7A (write) or 0x7B (read). Any other address is not acknowledged, and every byte after it gets no acknowledge and no write until the next start.
- R2: In a write transaction, a byte with bit 7 set while addresses are expected is a row address. Bit 5 selects the space (0 character codes, 1 attributes/control) and bits 3:0 give the row. Such a byte is acknowledged and causes no write.
- R3: A byte with bit 7 clear while addresses are expected is a column address, given by bits 4:0. If bit 6 is clear, exactly one following byte is written at the held row and column, and then addresses are expected again. This lets a transaction send only a new column (keeping the row) or a new row and column before each data byte.
- R4: A column byte with bit 6 set starts streaming. Every byte after it, including bytes with bit 7 set, is written as data until STOP or a new START.
- R5: While streaming in rows 0 to 14, the column advances after each write. Column 29 is followed by column 0 of the next row, and row 14 column 29 is followed by row 0 column 0.
- R6: While streaming in row 15, only the column advances, and column 31 is followed by column 0 of row 15.
- R7: A data byte that arrives before both a row and a column have been received since the last start produces no write.
- R8: Each accepted data byte gives a one-cycle `wr_en_o` pulse one cycle after the byte, with the space, row, column and byte on the write outputs.
- R9: Data for attribute/control row 15 columns 24 or 31 produces no write strobe. A stream still advances past those columns.
- R10: A write to attribute/control row 15 column 17 pulses `clr_win_o` with data bit 2 and `clr_disp_o` with data bit 1, in the same cycle as its strobe. No other write pulses either output.
- R11: `tx_byte_o` always shows the reset-flag register, with the flag in bit 1 and all other bits 0. Reset clears the flag, and a write to attribute/control row 15 column 23 loads the flag from data bit 1. `rd_active_o` is high from the cycle after a 0x7B address byte until STOP or START.
- R12: A stop condition ends the transaction. Bytes that follow it without a new start are neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: start or repeated start seen |
| stop_i | input | 1 | One-cycle pulse: stop seen |
| rx_valid_i | input | 1 | One-cycle pulse: a received byte is on `rx_byte_i` |
| rx_byte_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge decision for the previous byte |
| rd_active_o | output | 1 | A read transaction is in progress |
| tx_byte_o | output | 8 | Byte to return on a read (reset-flag register) |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_space_o | output | 1 | Write space: 0 codes, 1 attributes/control |
| wr_row_o | output | 4 | Write row |
| wr_col_o | output | 5 | Write column |
| wr_data_o | output | 8 | Write data |
| clr_win_o | output | 1 | Pulse: clear all window enables |
| clr_disp_o | output | 1 | Pulse: clear display codes and colour/blink bits |

## Verification
Some properties are checked on every cycle. A strobe always follows a received byte and never lands on the two reserved control columns. Streaming stays locked until STOP or START, STOP always returns the decoder to idle, and dropped data never strobes. Clear pulses appear only with a strobe to the screen-control register, and the read byte changes only with a write to the flag register. Other behaviour can only be shown by the bench scenarios: the exact address sequence of a stream across row and screen wraps, the mixing of formats within one transaction, the acknowledge pattern for foreign addresses, and the flag surviving until reset.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;

  localparam int ROW_W = 4;
  localparam int COL_W = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SLAVE, PH_ADDR, PH_DATA, PH_STREAM, PH_READ, PH_SKIP
  } phase_t;

  typedef struct packed {
    logic             space;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } waddr_t;

  // address that follows a in streaming mode
  function automatic waddr_t stream_step(waddr_t a, int n_rows, int n_cols, int ctrl_row);
    waddr_t n;
    n = a;
    if (int'(a.row) == ctrl_row) begin
      n.col = a.col + 1'b1;
    end else if (int'(a.col) >= n_cols - 1) begin
      n.col = '0;
      n.row = (int'(a.row) >= n_rows - 1) ? '0 : a.row + 1'b1;
    end else begin
      n.col = a.col + 1'b1;
    end
    return n;
  endfunction

  function automatic logic hits_ctrl(waddr_t a, int ctrl_row, int col);
    return a.space && (int'(a.row) == ctrl_row) && (int'(a.col) == col);
  endfunction

  function automatic logic is_reserved(waddr_t a, int ctrl_row, int res_a, int res_b);
    return hits_ctrl(a, ctrl_row, res_a) || hits_ctrl(a, ctrl_row, res_b);
  endfunction

endpackage

// File: rtl/osd_byte_classify.sv
module osd_byte_classify
  import osd_cmd_pkg::*;
(
  input  logic [7:0]       byte_i,
  output logic             is_row_o,
  output logic             col_stream_o,
  output logic             row_space_o,
  output logic [ROW_W-1:0] row_num_o,
  output logic [COL_W-1:0] col_num_o
);
  always_comb begin
    is_row_o     = byte_i[7];
    col_stream_o = byte_i[6];
    row_space_o  = byte_i[5];
    row_num_o    = byte_i[ROW_W-1:0];
    col_num_o    = byte_i[COL_W-1:0];
  end
endmodule

// File: rtl/osd_addr_track.sv
module osd_addr_track
  import osd_cmd_pkg::*;
#(
  parameter int         N_ROWS   = 15,
  parameter int         N_COLS   = 30,
  parameter int         CTRL_ROW = 15,
  parameter logic [7:0] SLV_WR   = 8'h7A,
  parameter logic [7:0] SLV_RD   = 8'h7B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             is_row_i,
  input  logic             col_stream_i,
  input  logic             row_space_i,
  input  logic [ROW_W-1:0] row_num_i,
  input  logic [COL_W-1:0] col_num_i,
  output phase_t           phase_o,
  output waddr_t           addr_o,
  output logic             data_fire_o,
  output logic             data_drop_o,
  output logic             ack_fire_o
);
  phase_t ph;
  waddr_t addr;
  logic   have_row, have_col;
  logic   byte_in, data_byte;

  always_comb begin
    byte_in     = rx_valid_i && !start_i;
    data_byte   = byte_in && (ph == PH_DATA || ph == PH_STREAM);
    data_fire_o = data_byte && have_row && have_col;
    data_drop_o = data_byte && !(have_row && have_col);
    ack_fire_o  = byte_in &&
                  ((ph == PH_SLAVE && (rx_byte_i == SLV_WR || rx_byte_i == SLV_RD)) ||
                   ph == PH_ADDR || ph == PH_DATA || ph == PH_STREAM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      addr     <= '0;
      have_row <= 1'b0;
      have_col <= 1'b0;
    end else if (start_i) begin
      ph       <= PH_SLAVE;
      have_row <= 1'b0;
      have_col <= 1'b0;
    end else if (stop_i) begin
      ph <= PH_IDLE;
    end else if (rx_valid_i) begin
      case (ph)
        PH_SLAVE:  ph <= (rx_byte_i == SLV_WR) ? PH_ADDR :
                         ((rx_byte_i == SLV_RD) ? PH_READ : PH_SKIP);
        PH_ADDR: begin
          if (is_row_i) begin
            addr.space <= row_space_i;
            addr.row   <= row_num_i;
            have_row   <= 1'b1;
          end else begin
            addr.col <= col_num_i;
            have_col <= 1'b1;
            ph       <= col_stream_i ? PH_STREAM : PH_DATA;
          end
        end
        PH_DATA:   ph <= PH_ADDR;
        PH_STREAM: if (data_fire_o) addr <= stream_step(addr, N_ROWS, N_COLS, CTRL_ROW);
        default:   ;
      endcase
    end
  end

  assign phase_o = ph;
  assign addr_o  = addr;
endmodule

// File: rtl/osd_write_port.sv
module osd_write_port
  import osd_cmd_pkg::*;
#(
  parameter int CTRL_ROW    = 15,
  parameter int RES_COL_A   = 24,
  parameter int RES_COL_B   = 31,
  parameter int CLR_COL     = 17,
  parameter int FLAG_COL    = 23,
  parameter int FLAG_BIT    = 1,
  parameter int WIN_CLR_BIT = 2,
  parameter int DSP_CLR_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_fire_i,
  input  logic             ack_fire_i,
  input  waddr_t           addr_i,
  input  logic [7:0]       byte_i,
  output logic             rsv_hit_o,
  output logic             ack_o,
  output logic             wr_en_o,
  output logic             wr_space_o,
  output logic [ROW_W-1:0] wr_row_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic [7:0]       wr_data_o,
  output logic             clr_win_o,
  output logic             clr_disp_o,
  output logic             flag_o
);
  logic hit_clr, hit_flag;

  always_comb begin
    rsv_hit_o = data_fire_i && is_reserved(addr_i, CTRL_ROW, RES_COL_A, RES_COL_B);
    hit_clr   = data_fire_i && hits_ctrl(addr_i, CTRL_ROW, CLR_COL);
    hit_flag  = data_fire_i && hits_ctrl(addr_i, CTRL_ROW, FLAG_COL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o      <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_space_o <= 1'b0;
      wr_row_o   <= '0;
      wr_col_o   <= '0;
      wr_data_o  <= '0;
      clr_win_o  <= 1'b0;
      clr_disp_o <= 1'b0;
      flag_o     <= 1'b0;
    end else begin
      ack_o      <= ack_fire_i;
      wr_en_o    <= data_fire_i && !rsv_hit_o;
      clr_win_o  <= hit_clr && byte_i[WIN_CLR_BIT];
      clr_disp_o <= hit_clr && byte_i[DSP_CLR_BIT];
      if (data_fire_i) begin
        wr_space_o <= addr_i.space;
        wr_row_o   <= addr_i.row;
        wr_col_o   <= addr_i.col;
        wr_data_o  <= byte_i;
      end
      if (hit_flag) flag_o <= byte_i[FLAG_BIT];
    end
  end
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter int         N_ROWS      = 15,
  parameter int         N_COLS      = 30,
  parameter int         CTRL_ROW    = 15,
  parameter int         RES_COL_A   = 24,
  parameter int         RES_COL_B   = 31,
  parameter int         CLR_COL     = 17,
  parameter int         FLAG_COL    = 23,
  parameter int         FLAG_BIT    = 1,
  parameter int         WIN_CLR_BIT = 2,
  parameter int         DSP_CLR_BIT = 1,
  parameter logic [7:0] SLV_WR      = 8'h7A,
  parameter logic [7:0] SLV_RD      = 8'h7B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  output logic             ack_o,
  output logic             rd_active_o,
  output logic [7:0]       tx_byte_o,
  output logic             wr_en_o,
  output logic             wr_space_o,
  output logic [ROW_W-1:0] wr_row_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic [7:0]       wr_data_o,
  output logic             clr_win_o,
  output logic             clr_disp_o
);
  // named internal events, also observed by the checker
  phase_t           ph_now;
  waddr_t           cur_addr;
  logic             data_fire, data_drop, ack_fire, rsv_hit, flag_q;
  logic             c_is_row, c_stream, c_space;
  logic [ROW_W-1:0] c_row;
  logic [COL_W-1:0] c_col;

  osd_byte_classify u_cls (
    .byte_i(rx_byte_i), .is_row_o(c_is_row), .col_stream_o(c_stream),
    .row_space_o(c_space), .row_num_o(c_row), .col_num_o(c_col)
  );

  osd_addr_track #(
    .N_ROWS(N_ROWS), .N_COLS(N_COLS), .CTRL_ROW(CTRL_ROW),
    .SLV_WR(SLV_WR), .SLV_RD(SLV_RD)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
    .is_row_i(c_is_row), .col_stream_i(c_stream), .row_space_i(c_space),
    .row_num_i(c_row), .col_num_i(c_col),
    .phase_o(ph_now), .addr_o(cur_addr), .data_fire_o(data_fire),
    .data_drop_o(data_drop), .ack_fire_o(ack_fire)
  );

  osd_write_port #(
    .CTRL_ROW(CTRL_ROW), .RES_COL_A(RES_COL_A), .RES_COL_B(RES_COL_B),
    .CLR_COL(CLR_COL), .FLAG_COL(FLAG_COL), .FLAG_BIT(FLAG_BIT),
    .WIN_CLR_BIT(WIN_CLR_BIT), .DSP_CLR_BIT(DSP_CLR_BIT)
  ) u_wp (
    .clk(clk), .rst_n(rst_n), .data_fire_i(data_fire), .ack_fire_i(ack_fire),
    .addr_i(cur_addr), .byte_i(rx_byte_i), .rsv_hit_o(rsv_hit), .ack_o(ack_o),
    .wr_en_o(wr_en_o), .wr_space_o(wr_space_o), .wr_row_o(wr_row_o),
    .wr_col_o(wr_col_o), .wr_data_o(wr_data_o), .clr_win_o(clr_win_o),
    .clr_disp_o(clr_disp_o), .flag_o(flag_q)
  );

  assign rd_active_o = (ph_now == PH_READ);
  assign tx_byte_o   = flag_q ? (8'd1 << FLAG_BIT) : 8'd0;
endmodule

// File: rtl/osd_cmd_checker.sv
module osd_cmd_checker
  import osd_cmd_pkg::*;
#(
  parameter int         CTRL_ROW  = 15,
  parameter int         RES_COL_A = 24,
  parameter int         RES_COL_B = 31,
  parameter int         CLR_COL   = 17,
  parameter int         FLAG_COL  = 23,
  parameter logic [7:0] SLV_WR    = 8'h7A,
  parameter logic [7:0] SLV_RD    = 8'h7B
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic             rx_valid_i,
  input logic [7:0]       rx_byte_i,
  input logic             ack_o,
  input logic [7:0]       tx_byte_o,
  input logic             wr_en_o,
  input logic             wr_space_o,
  input logic [ROW_W-1:0] wr_row_o,
  input logic [COL_W-1:0] wr_col_o,
  input logic             clr_win_o,
  input logic             clr_disp_o,
  input phase_t           ph,
  input logic             drop
);
  logic at_ctrl;
  assign at_ctrl = wr_space_o && (wr_row_o == ROW_W'(CTRL_ROW));

  p_ack_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !start_i && ph == PH_SLAVE && (rx_byte_i == SLV_WR || rx_byte_i == SLV_RD)) |=> ack_o);

  p_stream_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STREAM && !start_i && !stop_i) |=> (ph == PH_STREAM));

  p_drop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !wr_en_o);

  p_strobe_after_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(rx_valid_i));

  p_reserved_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !(at_ctrl && (wr_col_o == COL_W'(RES_COL_A) || wr_col_o == COL_W'(RES_COL_B))));

  p_clear_with_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_win_o || clr_disp_o) |-> (wr_en_o && at_ctrl && wr_col_o == COL_W'(CLR_COL)));

  p_flag_moves_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_byte_o) |-> (wr_en_o && at_ctrl && wr_col_o == COL_W'(FLAG_COL)));

  p_idle_after_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (ph == PH_IDLE));
endmodule

bind osd_cmd_decoder osd_cmd_checker #(
  .CTRL_ROW(CTRL_ROW), .RES_COL_A(RES_COL_A), .RES_COL_B(RES_COL_B),
  .CLR_COL(CLR_COL), .FLAG_COL(FLAG_COL), .SLV_WR(SLV_WR), .SLV_RD(SLV_RD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .ack_o(ack_o),
  .tx_byte_o(tx_byte_o), .wr_en_o(wr_en_o), .wr_space_o(wr_space_o),
  .wr_row_o(wr_row_o), .wr_col_o(wr_col_o), .clr_win_o(clr_win_o),
  .clr_disp_o(clr_disp_o), .ph(ph_now), .drop(data_drop)
);

// File: tb/sim_osd_cmd_decoder.sv
`timescale 1ns/1ps
module sim_osd_cmd_decoder;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       ack_o, rd_active_o, wr_en_o, wr_space_o, clr_win_o, clr_disp_o;
  logic [7:0] tx_byte_o, wr_data_o;
  logic [3:0] wr_row_o;
  logic [4:0] wr_col_o;

  osd_cmd_decoder u0 (.*);

  always #2 clk = ~clk;

  int n_run = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model: 0 idle, 1 slave, 2 addr, 3 data, 4 stream, 5 read, 6 skip
  int m_ph = 0, m_row = 0, m_col = 0, m_sp = 0, m_hr = 0, m_hc = 0, m_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int next_lin(int r, int c);
    if (r == 15) return (15 << 8) | ((c + 1) % 32);
    return (((r * 30 + c + 1) % 450) / 30 << 8) | ((r * 30 + c + 1) % 30);
  endfunction

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    m_ph = 1; m_hr = 0; m_hc = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    m_ph = 0;
    chk(rd_active_o == 1'b0, "R12 rd_active after stop", rd_active_o, 0);
  endtask

  task automatic put(input logic [7:0] b);
    int e_ack = 0, e_wr = 0, e_cw = 0, e_cd = 0, e_r = 0, e_c = 0, e_s = 0, nx;
    bit wrote = 0;
    case (m_ph)
      1: begin e_ack = (b == 8'h7A || b == 8'h7B); m_ph = (b == 8'h7A) ? 2 : ((b == 8'h7B) ? 5 : 6); end
      2: begin
        e_ack = 1;
        if (b[7]) begin m_sp = b[5]; m_row = b[3:0]; m_hr = 1; end
        else begin m_col = b[4:0]; m_hc = 1; m_ph = b[6] ? 4 : 3; end
      end
      3, 4: begin
        e_ack = 1;
        if (m_hr && m_hc) begin
          wrote = 1; e_r = m_row; e_c = m_col; e_s = m_sp;
          e_wr = !(m_sp == 1 && m_row == 15 && (m_col == 24 || m_col == 31));
          if (m_sp == 1 && m_row == 15 && m_col == 17) begin e_cw = b[2]; e_cd = b[1]; end
          if (m_sp == 1 && m_row == 15 && m_col == 23) m_flag = b[1];
          if (m_ph == 4) begin nx = next_lin(m_row, m_col); m_row = nx >> 8; m_col = nx & 255; end
        end
        if (m_ph == 3) m_ph = 2;
      end
      default: ;
    endcase
    @(negedge clk); rx_valid_i = 1'b1; rx_byte_i = b;
    @(negedge clk); rx_valid_i = 1'b0;
    chk(ack_o == e_ack[0], "R1 R12 acknowledge", ack_o, e_ack);
    chk(wr_en_o == e_wr[0], wrote ? "R8 R9 strobe" : "R2 R7 R12 no strobe", wr_en_o, e_wr);
    if (e_wr != 0) begin
      chk(wr_row_o == e_r[3:0] && wr_col_o == e_c[4:0] && wr_space_o == e_s[0],
          "R3 R5 R6 write address", {wr_space_o, wr_row_o, wr_col_o}, (e_s << 9) | (e_r << 5) | e_c);
      chk(wr_data_o == b, "R4 R8 write data", wr_data_o, b);
    end
    chk(clr_win_o == e_cw[0] && clr_disp_o == e_cd[0], "R10 clear pulses",
        {clr_win_o, clr_disp_o}, (e_cw << 1) | e_cd);
    chk(tx_byte_o == 8'(m_flag << 1), "R11 flag byte", tx_byte_o, m_flag << 1);
    chk(rd_active_o == (m_ph == 5), "R11 read active", rd_active_o, m_ph == 5);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    m_ph = 0; m_hr = 0; m_hc = 0; m_flag = 0; m_row = 0; m_col = 0; m_sp = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    int seed, kind, len, r, c;
    seed = $urandom(32'h5EED0A7);
    do_reset();
    chk(wr_en_o == 0 && ack_o == 0 && tx_byte_o == 0 && rd_active_o == 0 && clr_win_o == 0 && clr_disp_o == 0,
        "R11 reset state", {wr_en_o, ack_o, tx_byte_o}, 0);

    // R1: foreign address, then ignored bytes
    do_start(); put(8'h55); put(8'h83); put(8'h05); put(8'h41); do_stop();
    // R2 R3: random-access form, then row kept with new column, then new row
    do_start(); put(8'h7A); put(8'h83); put(8'h05); put(8'h41);
    put(8'h06); put(8'h42); put(8'hA2); put(8'h00); put(8'h17); do_stop();
    // R5 R4: stream across last row to row 0, data byte with bit 7 set
    do_start(); put(8'h7A); put(8'h8E); put(8'h5C); put(8'h11); put(8'h9F); put(8'hC3); put(8'h22); do_stop();
    // R6 R9: control row stream through reserved column 31 and wrap
    do_start(); put(8'h7A); put(8'hAF); put(8'h5E); put(8'h01); put(8'h02); put(8'h03); do_stop();
    // R9: reserved column 24 random-access
    do_start(); put(8'h7A); put(8'hAF); put(8'h18); put(8'hFF); do_stop();
    // R7: column before row, data dropped; stream without row dropped
    do_start(); put(8'h7A); put(8'h04); put(8'h33); put(8'h44); do_stop();
    do_start(); put(8'h7A); put(8'h44); put(8'h55); put(8'h66); do_stop();
    // R10: clears
    do_start(); put(8'h7A); put(8'hAF); put(8'h11); put(8'h06);
    put(8'h11); put(8'h04); put(8'h11); put(8'h02); do_stop();
    // R11: flag read, set, read, reset clears
    do_start(); put(8'h7B); do_stop();
    do_start(); put(8'h7A); put(8'hAF); put(8'h17); put(8'h02); do_stop();
    do_start(); put(8'h7B); do_stop();
    chk(tx_byte_o == 8'h02, "R11 flag kept", tx_byte_o, 8'h02);
    do_reset();
    chk(tx_byte_o == 8'h00, "R11 flag cleared by reset", tx_byte_o, 0);
    // R12: bytes after stop ignored
    do_start(); put(8'h7A); put(8'h81); do_stop(); put(8'h02); put(8'h99);

    // random traffic
    for (int t = 0; t < 60; t++) begin
      kind = $urandom % 4;
      do_start();
      if (kind == 3) begin put(8'h7B); do_stop(); continue; end
      put(8'h7A);
      if (kind == 0) begin
        r = $urandom % 16; c = (r == 15) ? $urandom % 32 : $urandom % 30;
        put(8'(8'h80 | (($urandom % 2) << 5) | r)); put(8'(8'h40 | c));
        len = 1 + $urandom % 40;
        for (int k = 0; k < len; k++) put(8'($urandom));
      end else begin
        len = 1 + $urandom % 5;
        for (int k = 0; k < len; k++) begin
          if (kind == 1 || k == 0) begin
            r = $urandom % 16;
            put(8'(8'h80 | (($urandom % 2) << 5) | r));
          end
          c = (r == 15) ? $urandom % 32 : $urandom % 30;
          put(8'(c)); put(8'($urandom));
        end
      end
      do_stop();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule